// File: doc/BRIEF.md
# Two-Port Grouped Memory Arbiter

This block sits in front of an on-chip memory split into equal-sized groups and serves two requesters at once. A wide system-bus port reads a full 128-bit line and writes one 64-bit half of a line. A narrow local-bus port reads and writes 64-bit halves. Each cycle the block works out which port owns each group, gives a contested group to the local-bus port, and holds the system-bus port off with a low ready. The system-bus request is served in the first cycle that it no longer collides.

When the two ports address different groups they proceed in the same cycle, so the memory delivers up to two accesses per clock. Each group is modelled as a simple synchronous single-port array. Read data comes back one cycle after acceptance, together with a one-cycle valid pulse on the port that issued the read. Addresses are byte addresses without their three least significant bits. The group size (32 KB by default) and the number of groups are parameters.

Top module: `grouped_mem_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sb_rvalid` and `lb_rvalid` are low.
- R2: The group index is the address bits at and above bit log2(GRP_BYTES). The line within a group is taken from bits log2(GRP_BYTES)-1 down to 4, so two addresses that differ only in bits below 4 reach the same line.
- R3: A system-bus read is accepted in a cycle where `sb_valid` and `sb_ready` are high and `sb_we` is low. In the next cycle `sb_rvalid` is high for one cycle and `sb_rdata` carries the whole 128-bit line. Bits 127:64 of the line are the half addressed with bit 3 set.
- R4: A system-bus write stores `sb_wdata` into the upper half of the line when address bit 3 is 1 and into the lower half when it is 0. The other half is left unchanged.
- R5: A local-bus read returns, one cycle after acceptance, the 64-bit half picked by address bit 3, with `lb_rvalid` high for that one cycle. A local-bus write stores the half picked by bit 3.
- R6: `lb_ready` is always high, so every local-bus request is served in the cycle it is presented.
- R7: When both ports are valid and address the same group, the local-bus access is performed and `sb_ready` is low.
- R8: When both ports are valid and address different groups, `sb_ready` is high and both accesses are performed in that cycle.
- R9: A system-bus request that is stalled keeps `sb_valid`, `sb_we`, `sb_addr` and `sb_wdata` unchanged until it is accepted. It is then served exactly once.
- R10: Both ports share one storage. Data written through either port is seen by later reads from either port. A stalled system-bus read that lost to a local-bus write returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_valid | input | 1 | System-bus request valid |
| sb_we | input | 1 | System-bus write (1) or read (0) |
| sb_addr | input | ADDR_W-3 | System-bus byte address, bits ADDR_W-1 down to 3 |
| sb_wdata | input | 64 | System-bus write half-line |
| sb_ready | output | 1 | System-bus request accepted this cycle |
| sb_rvalid | output | 1 | System-bus read data valid |
| sb_rdata | output | 128 | System-bus read line |
| lb_valid | input | 1 | Local-bus request valid |
| lb_we | input | 1 | Local-bus write (1) or read (0) |
| lb_addr | input | ADDR_W-3 | Local-bus byte address, bits ADDR_W-1 down to 3 |
| lb_wdata | input | 64 | Local-bus write half-line |
| lb_ready | output | 1 | Local-bus request accepted (always high) |
| lb_rvalid | output | 1 | Local-bus read data valid |
| lb_rdata | output | 64 | Local-bus read half-line |

## Verification
The block holds little state: the group ownership decision and the registered return path. A wrong ownership decision shows at `sb_ready` in the same cycle it is made. If it lets both ports into one group, it also shows as corrupted data on a later read of that line. A stale group or half register in the return path shows one cycle after acceptance as data from the wrong group or the wrong half of the line. A lost or doubled valid shows as a missing or unexpected valid pulse. A half-line write that touches the wrong half is invisible until the line is read back, so the bench reads every line it has written, through both ports, and compares the reads against its own model of the storage.

// File: rtl/gmx_pkg.sv
// Shared widths and types for the grouped memory arbiter.
package gmx_pkg;
    localparam int HALF_W = 64;
    localparam int LINE_W = 128;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/gmx_addr_split.sv
// Splits a byte address (bits 2:0 already dropped) into group index,
// line index within the group and half-line select.
// Assumes GRP_BYTES is a power of two of at least 32 and the group
// count is a power of two.
module gmx_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 15,
    localparam int GW    = ADDR_W - OFF_W,
    localparam int IW    = OFF_W - 4
) (
    input  logic [ADDR_W-1:3] addr,
    output logic [GW-1:0]     grp,
    output logic [IW-1:0]     widx,
    output logic              half
);
    // Slice the address into its three fields.
    always_comb begin
        grp  = addr[ADDR_W-1:OFF_W];
        widx = addr[OFF_W-1:4];
        half = addr[3];
    end
endmodule

// File: rtl/gmx_group_arb.sv
// Per-group owner selection. The local-bus port always wins a group it
// targets; the system-bus port gets a group only if the local-bus port
// is not using it. Purely combinational.
module gmx_group_arb #(
    parameter int NUM_GRP = 2,
    parameter int GW      = 1
) (
    input  logic               sb_v,
    input  logic [GW-1:0]      sb_grp,
    input  logic               lb_v,
    input  logic [GW-1:0]      lb_grp,
    output logic [NUM_GRP-1:0] sb_sel,
    output logic [NUM_GRP-1:0] lb_sel,
    output logic               sb_grant
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_own
        // Decide the owner of group g for this cycle.
        always_comb begin
            lb_sel[g] = lb_v && (lb_grp == GW'(g));
            sb_sel[g] = sb_v && (sb_grp == GW'(g)) && !lb_sel[g];
        end
    end

    // The system-bus port proceeds when it owns its group.
    assign sb_grant = |sb_sel;
endmodule

// File: rtl/gmx_bank.sv
// One memory group: a single-port synchronous array of 128-bit lines.
// A write stores one 64-bit half; a read registers the whole line.
// The output register keeps its value until the next read of this group.
// The storage has no reset.
module gmx_bank
    import gmx_pkg::*;
#(
    parameter int WORDS = 2048,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic          half,
    input  logic [IW-1:0] idx,
    input  half_t         wdata,
    output line_t         rdata
);
    line_t mem [WORDS];

    // Perform the one access granted to this group this cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                if (half) mem[idx][LINE_W-1:HALF_W] <= wdata;
                else      mem[idx][HALF_W-1:0]      <= wdata;
            end else begin
                rdata <= mem[idx];
            end
        end
    end
endmodule

// File: rtl/grouped_mem_arbiter.sv
// Two-port front end for a grouped on-chip memory.
// - System-bus port: 128-bit reads, 64-bit half-line writes, valid/ready.
// - Local-bus port: 64-bit reads and writes, never stalled.
// A group accessed by both ports in one cycle goes to the local bus. The
// two ports run in parallel on different groups. Read data returns one
// cycle after acceptance.
// Assumes: NUM_GRP and GRP_BYTES are powers of two, and a stalled
// system-bus requester holds its request stable.
module grouped_mem_arbiter
    import gmx_pkg::*;
#(
    parameter int GRP_BYTES = 32768,
    parameter int NUM_GRP   = 2,
    parameter int ADDR_W    = $clog2(GRP_BYTES) + $clog2(NUM_GRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_valid,
    input  logic              sb_we,
    input  logic [ADDR_W-1:3] sb_addr,
    input  logic [63:0]       sb_wdata,
    output logic              sb_ready,
    output logic              sb_rvalid,
    output logic [127:0]      sb_rdata,
    input  logic              lb_valid,
    input  logic              lb_we,
    input  logic [ADDR_W-1:3] lb_addr,
    input  logic [63:0]       lb_wdata,
    output logic              lb_ready,
    output logic              lb_rvalid,
    output logic [63:0]       lb_rdata
);
    localparam int OFF_W = $clog2(GRP_BYTES);
    localparam int GW    = ADDR_W - OFF_W;
    localparam int IW    = OFF_W - 4;
    localparam int WORDS = GRP_BYTES / 16;

    logic [GW-1:0] sb_grp, lb_grp;
    logic [IW-1:0] sb_widx, lb_widx;
    logic          sb_half, lb_half;

    gmx_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_sb_split (
        .addr(sb_addr), .grp(sb_grp), .widx(sb_widx), .half(sb_half)
    );
    gmx_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lb_split (
        .addr(lb_addr), .grp(lb_grp), .widx(lb_widx), .half(lb_half)
    );

    logic [NUM_GRP-1:0] sb_sel, lb_sel;
    logic               sb_grant;

    gmx_group_arb #(.NUM_GRP(NUM_GRP), .GW(GW)) u_arb (
        .sb_v(sb_valid), .sb_grp(sb_grp), .lb_v(lb_valid), .lb_grp(lb_grp),
        .sb_sel(sb_sel), .lb_sel(lb_sel), .sb_grant(sb_grant)
    );

    assign sb_ready = sb_grant;
    assign lb_ready = 1'b1;

    line_t b_rd [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
        logic          b_en, b_we, b_half;
        logic [IW-1:0] b_idx;
        half_t         b_wd;

        // Steer the owning port's request into group g.
        always_comb begin
            b_en   = lb_sel[g] | sb_sel[g];
            b_we   = lb_sel[g] ? lb_we    : sb_we;
            b_half = lb_sel[g] ? lb_half  : sb_half;
            b_idx  = lb_sel[g] ? lb_widx  : sb_widx;
            b_wd   = lb_sel[g] ? lb_wdata : sb_wdata;
        end

        gmx_bank #(.WORDS(WORDS)) u_bank (
            .clk(clk), .en(b_en), .we(b_we), .half(b_half),
            .idx(b_idx), .wdata(b_wd), .rdata(b_rd[g])
        );
    end

    logic          sb_rv_q, lb_rv_q, lb_half_q;
    logic [GW-1:0] sb_grp_q, lb_grp_q;

    // Remember which group and half each accepted read will come from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_rv_q   <= 1'b0;
            lb_rv_q   <= 1'b0;
            sb_grp_q  <= '0;
            lb_grp_q  <= '0;
            lb_half_q <= 1'b0;
        end else begin
            sb_rv_q <= sb_valid & sb_grant & ~sb_we;
            lb_rv_q <= lb_valid & ~lb_we;
            if (sb_valid & sb_grant) sb_grp_q <= sb_grp;
            if (lb_valid) begin
                lb_grp_q  <= lb_grp;
                lb_half_q <= lb_half;
            end
        end
    end

    // Route the registered group lines back to each port.
    always_comb begin
        sb_rvalid = sb_rv_q;
        sb_rdata  = b_rd[sb_grp_q];
        lb_rvalid = lb_rv_q;
        lb_rdata  = lb_half_q ? b_rd[lb_grp_q][LINE_W-1:HALF_W]
                              : b_rd[lb_grp_q][HALF_W-1:0];
    end

    // Port-level checks on ownership, stalls and the return path.
    assert_conflict_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && lb_valid && sb_addr[ADDR_W-1:OFF_W] == lb_addr[ADDR_W-1:OFF_W])
        |-> !sb_ready);

    assert_parallel_serve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && lb_valid && sb_addr[ADDR_W-1:OFF_W] != lb_addr[ADDR_W-1:OFF_W])
        |-> sb_ready);

    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_ready)
        |=> (sb_valid && $stable(sb_we) && $stable(sb_addr) && $stable(sb_wdata)));

    assert_sb_read_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && sb_ready && !sb_we) |=> sb_rvalid);

    assert_sb_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sb_rvalid |-> $past(sb_valid && sb_ready && !sb_we));

    assert_lb_read_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && !lb_we) |=> lb_rvalid);

    assert_lb_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rvalid |-> $past(lb_valid && !lb_we));
endmodule

// File: tb/grouped_mem_arbiter_tb_top.sv
module grouped_mem_arbiter_tb_top;
    localparam int GB = 64;
    localparam int NG = 4;
    localparam int OW = $clog2(GB);
    localparam int AW = OW + $clog2(NG);
    localparam int NW = NG * GB / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          sb_valid = 0, sb_we = 0, lb_valid = 0, lb_we = 0;
    logic [AW-1:3] sb_addr = '0, lb_addr = '0;
    logic [63:0]   sb_wdata = '0, lb_wdata = '0;
    logic          sb_ready, sb_rvalid, lb_ready, lb_rvalid;
    logic [127:0]  sb_rdata;
    logic [63:0]   lb_rdata;

    grouped_mem_arbiter #(.GRP_BYTES(GB), .NUM_GRP(NG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sb_valid(sb_valid), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
        .sb_ready(sb_ready), .sb_rvalid(sb_rvalid), .sb_rdata(sb_rdata),
        .lb_valid(lb_valid), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_ready(lb_ready), .lb_rvalid(lb_rvalid), .lb_rdata(lb_rdata)
    );

    int compared = 0;
    int mismatched = 0;
    logic [127:0] mdl [NW];
    logic [127:0] sb_q [$];
    logic [63:0]  lb_q [$];
    string        sb_tq [$];
    string        lb_tq [$];

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present both ports for one cycle, predict ready and results.
    task automatic do_cyc(input logic sv, input logic sw, input logic [AW-1:0] sa,
                          input logic [63:0] sd, input logic lv, input logic lw,
                          input logic [AW-1:0] la, input logic [63:0] ld,
                          input string tag, output logic s_acc);
        logic exp_rdy;
        @(negedge clk);
        sb_valid = sv; sb_we = sw; sb_addr = sa[AW-1:3]; sb_wdata = sd;
        lb_valid = lv; lb_we = lw; lb_addr = la[AW-1:3]; lb_wdata = ld;
        #1;
        exp_rdy = sv && !(lv && sa[AW-1:OW] == la[AW-1:OW]);
        if (sv) chk(sb_ready == exp_rdy,
                    (lv && sa[AW-1:OW] == la[AW-1:OW]) ? "R7" : "R8",
                    128'(sb_ready), 128'(exp_rdy));
        if (lv) chk(lb_ready == 1'b1, "R6", 128'(lb_ready), 128'd1);
        s_acc = exp_rdy;
        if (exp_rdy && !sw) begin
            sb_q.push_back(mdl[sa[AW-1:4]]);
            sb_tq.push_back(tag);
        end
        if (lv && !lw) begin
            lb_q.push_back(la[3] ? mdl[la[AW-1:4]][127:64] : mdl[la[AW-1:4]][63:0]);
            lb_tq.push_back(tag);
        end
        if (exp_rdy && sw) begin
            if (sa[3]) mdl[sa[AW-1:4]][127:64] = sd;
            else       mdl[sa[AW-1:4]][63:0]   = sd;
        end
        if (lv && lw) begin
            if (la[3]) mdl[la[AW-1:4]][127:64] = ld;
            else       mdl[la[AW-1:4]][63:0]   = ld;
        end
    endtask

    task automatic idle();
        logic a;
        do_cyc(0, 0, '0, '0, 0, 0, '0, '0, "", a);
    endtask

    // Hold a system-bus request until accepted (R9); local bus idle.
    task automatic sb_only(input logic sw, input logic [AW-1:0] sa,
                           input logic [63:0] sd, input string tag);
        logic a;
        do_cyc(1, sw, sa, sd, 0, 0, '0, '0, tag, a);
    endtask

    task automatic lb_only(input logic lw, input logic [AW-1:0] la,
                           input logic [63:0] ld, input string tag);
        logic a;
        do_cyc(0, 0, '0, '0, 1, lw, la, ld, tag, a);
    endtask

    // Monitor: compare returned reads against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb_rvalid) begin
                if (sb_q.size() == 0) chk(0, "R3", 128'(sb_rvalid), 128'd0);
                else begin
                    logic [127:0] e;
                    string t;
                    e = sb_q.pop_front();
                    t = sb_tq.pop_front();
                    chk(sb_rdata == e, t, sb_rdata, e);
                end
            end
            if (lb_rvalid) begin
                if (lb_q.size() == 0) chk(0, "R5", 128'(lb_rvalid), 128'd0);
                else begin
                    logic [63:0] e;
                    string t;
                    e = lb_q.pop_front();
                    t = lb_tq.pop_front();
                    chk(lb_rdata == e, t, 128'(lb_rdata), 128'(e));
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic acc;
        logic pv, pw, lv, lw;
        logic [AW-1:0] pa, la;
        logic [63:0] pd, ld;

        // R1: outputs quiet during and right after reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!sb_rvalid && !lb_rvalid, "R1", {sb_rvalid, lb_rvalid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sb_rvalid && !lb_rvalid, "R1", {sb_rvalid, lb_rvalid}, 128'd0);

        // R5: fill every half-line through the local bus.
        for (int w = 0; w < NW; w++)
            for (int h = 0; h < 2; h++)
                lb_only(1, AW'({w[AW-5:0], h[0], 3'b000}),
                        64'hC0DE_0000_0000_0000 | 64'(w << 8) | 64'(h), "R5");

        // R2/R3: system-bus line reads, low bits set, all groups.
        for (int w = 0; w < NW; w++)
            sb_only(0, AW'({w[AW-5:0], w[0], 3'b101}), '0, "R2");

        // R5: local-bus reads of both halves.
        for (int w = 0; w < NW; w += 3) begin
            lb_only(0, AW'({w[AW-5:0], 1'b0, 3'b000}), '0, "R5");
            lb_only(0, AW'({w[AW-5:0], 1'b1, 3'b111}), '0, "R5");
        end

        // R4: half-line writes from the system bus, then read back.
        sb_only(1, AW'({4'd5, 1'b1, 3'b000}), 64'h1111_2222_3333_4444, "R4");
        sb_only(1, AW'({4'd9, 1'b0, 3'b010}), 64'h5555_6666_7777_8888, "R4");
        sb_only(0, AW'({4'd5, 1'b0, 3'b000}), '0, "R4");
        sb_only(0, AW'({4'd9, 1'b1, 3'b000}), '0, "R4");
        lb_only(0, AW'({4'd5, 1'b0, 3'b000}), '0, "R4");
        lb_only(0, AW'({4'd9, 1'b1, 3'b000}), '0, "R4");

        // R8: different groups in the same cycle.
        do_cyc(1, 0, AW'({4'd1, 4'd0}), '0, 1, 1, AW'({4'd12, 4'd8}), 64'hABCD, "R8", acc);
        chk(acc == 1, "R8", 128'(acc), 128'd1);
        do_cyc(1, 1, AW'({4'd7, 4'd0}), 64'h77, 1, 0, AW'({4'd12, 4'd8}), '0, "R8", acc);
        lb_only(0, AW'({4'd7, 4'd0}), '0, "R10");

        // R7/R10: same-group conflict; stalled read then sees the new data.
        do_cyc(1, 0, AW'({4'd4, 4'd0}), '0, 1, 1, AW'({4'd6, 4'd8}), 64'hFEED, "R10", acc);
        do_cyc(1, 0, AW'({4'd4, 4'd0}), '0, 1, 1, AW'({4'd4, 4'd8}), 64'hBEEF, "R10", acc);
        chk(acc == 0 && sb_ready == 0, "R9", 128'(sb_ready), 128'd0);
        sb_only(0, AW'({4'd4, 4'd0}), '0, "R10");
        // R9: stalled write held over three conflicting cycles.
        for (int k = 0; k < 3; k++)
            do_cyc(1, 1, AW'({4'd10, 4'd8}), 64'h9999, 1, 0, AW'({4'(8 + k), 4'd0}), '0, "R7", acc);
        sb_only(1, AW'({4'd10, 4'd8}), 64'h9999, "R9");
        sb_only(0, AW'({4'd10, 4'd0}), '0, "R9");

        // Mixed traffic with held stalled requests.
        pv = 0; pw = 0; pa = '0; pd = '0;
        for (int i = 0; i < 400; i++) begin
            if (!pv && ($urandom % 4) != 0) begin
                pv = 1; pw = 1'($urandom % 2); pa = AW'($urandom);
                pd = {$urandom, $urandom};
            end
            lv = (($urandom % 3) != 0); lw = 1'($urandom % 2);
            la = AW'($urandom); ld = {$urandom, $urandom};
            do_cyc(pv, pw, pa, pd, lv, lw, la, ld, "R10", acc);
            if (acc) pv = 0;
        end

        idle(); idle(); idle();
        chk(sb_q.size() == 0 && lb_q.size() == 0, "R3",
            128'(sb_q.size() + lb_q.size()), 128'd0);
        finish_run();
    end
endmodule